// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Front End

This block is the bus-facing half of a 2048-byte serial EEPROM. It watches the two-wire clock and data lines through synchronizers, finds START and STOP conditions, receives the control byte and the word address, and answers with an acknowledge by enabling an open-drain pull-down on the data line. It keeps an 11-bit address pointer. The three block-select bits of the control byte form the upper part of the pointer, and the word address byte forms the lower part.

Every data byte that follows in a write is handed to the page buffer as a one-cycle strobe, together with its address. After each byte the pointer steps inside a 16-byte page. A STOP that closes a write carrying at least one data byte raises a commit strobe and starts a self-timed busy window. While that window lasts the block acknowledges nothing. A control byte with a foreign device code, or any read request, leaves the engine deaf until the next START. The read data path lives elsewhere.

Top module: `i2c_eeprom_slave_fe`

## Requirements
- R1: A falling data line while the clock is high (START) restarts control-byte reception from any state and discards a partly received byte. A rising data line while the clock is high (STOP) returns the engine to idle and releases the data line.
- R2: A control byte whose upper nibble (bits 7:4) equals 4'b1010 is acknowledged when no write cycle is running. The acknowledge asserts `sda_oe_o` from the clock fall after the eighth bit until the fall of the ninth clock.
- R3: A control byte with any other upper nibble is not acknowledged. Until the next START, no byte is acknowledged, no write strobe occurs and no commit follows.
- R4: For a write control byte (bit 0 = 0), bits 3:1 become pointer bits 10:8. The next byte is acknowledged and loaded into pointer bits 7:0.
- R5: Each later byte of a write, received most significant bit first, is acknowledged. It is presented on `wr_data_o`, with the pointer value on `wr_addr_o`, during a one-cycle `wr_valid_o` pulse.
- R6: After each data byte, pointer bits 3:0 increment modulo 16 and bits 10:4 stay unchanged.
- R7: A STOP after at least one data byte gives a one-cycle `commit_o` pulse. `busy_o` then stays high for WR_CYCLES clocks starting on the next cycle. A STOP with no data byte gives no commit.
- R8: While `busy_o` is high, no byte is acknowledged.
- R9: A matching control byte with bit 0 = 1 (read) is acknowledged. After it, no byte is acknowledged and no data is captured until the next START.
- R10: `sda_oe_o` changes only while the synchronized clock is low. The block never drives the data line high.
- R11: After reset, `sda_oe_o`, `busy_o`, `commit_o` and `wr_valid_o` are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_oe_o | output | 1 | Pull-down enable for the data line (1 = drive low) |
| ptr_o | output | 11 | Current address pointer |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 11 | Address of the byte on the strobe |
| wr_data_o | output | 8 | Received data byte |
| commit_o | output | 1 | One-cycle strobe that starts the write cycle |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The bench writes an 18-byte page that starts two bytes below the end of a 16-byte page. A design that carried into bit 4, or stopped at the page end, would leave a pointer other than 0x7F0. It addresses the block during the busy window, sends a foreign device code, sends a read request, and sends a write that stops right after the address byte. A design that acknowledged or committed in any of these cases would show a stray pull-down, strobe or busy window. A repeated START in the middle of a byte checks that stale bits are thrown away: a design that kept them would misload the next pointer. Every clock, the outputs are compared against a behavioural model driven by the same pin history.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CTRL = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } fe_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BITS_PER_BYTE = 8;
endpackage

// File: rtl/i2c_fe_line_mon.sv
module i2c_fe_line_mon #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], raw[l]};
    end
    assign synced[l] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_s_o    = synced[1];
  assign sda_s_o    = synced[0];
  // conditions need clock high on both samples
  assign start_o    = synced[1] & prev_q[1] &  prev_q[0] & ~synced[0];
  assign stop_o     = synced[1] & prev_q[1] & ~prev_q[0] &  synced[0];
  assign scl_rise_o =  synced[1] & ~prev_q[1];
  assign scl_fall_o = ~synced[1] &  prev_q[1];
endmodule

// File: rtl/i2c_fe_wr_timer.sv
module i2c_fe_wr_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (kick_i)         cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_eeprom_slave_fe.sv
module i2c_eeprom_slave_fe
  import i2c_fe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BLK_W       = 3,
  parameter int unsigned PAGE_W      = 4,
  parameter int unsigned WR_CYCLES   = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic              busy_o
);
  localparam int unsigned WORD_W  = ADDR_W - BLK_W;
  localparam int unsigned CNT_W   = 4;
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BITS_PER_BYTE);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BITS_PER_BYTE + 1);

  logic scl_s, sda_s, start, stop, scl_rise, scl_fall;

  i2c_fe_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  fe_state_e         state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [7:0]        shreg_q;
  logic [BLK_W-1:0]  blk_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              oe_q, got_q, commit_q, wv_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [7:0]        wdata_q;
  logic              busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      blk_q     <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      got_q     <= 1'b0;
      commit_q  <= 1'b0;
      wv_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      commit_q <= 1'b0;
      wv_q     <= 1'b0;
      if (start) begin
        state_q   <= ST_CTRL;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        got_q     <= 1'b0;
      end else if (stop) begin
        commit_q  <= got_q & ~busy;
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        got_q     <= 1'b0;
      end else if (scl_rise) begin
        // ack clock is still counted after a refusal so it can close
        if ((state_q != ST_IDLE || bit_cnt_q == CNT_BYTE) && bit_cnt_q < CNT_ACK)
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        if (state_q != ST_IDLE && bit_cnt_q < CNT_BYTE)
          shreg_q <= {shreg_q[6:0], sda_s};
      end else if (scl_fall) begin
        if (bit_cnt_q == CNT_ACK) begin
          oe_q      <= 1'b0;
          bit_cnt_q <= '0;
        end else if (bit_cnt_q == CNT_BYTE) begin
          unique case (state_q)
            ST_CTRL: begin
              if (shreg_q[7:4] == DEV_CODE && !busy) begin
                oe_q    <= 1'b1;
                blk_q   <= shreg_q[BLK_W:1];
                state_q <= shreg_q[0] ? ST_IDLE : ST_ADDR;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_ADDR: begin
              oe_q    <= 1'b1;
              ptr_q   <= {blk_q, shreg_q[WORD_W-1:0]};
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              oe_q    <= 1'b1;
              wv_q    <= 1'b1;
              waddr_q <= ptr_q;
              wdata_q <= shreg_q;
              got_q   <= 1'b1;
              ptr_q   <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
            end
            default: ;
          endcase
        end
      end
    end
  end

  i2c_fe_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (commit_q),
    .busy_o (busy)
  );

  assign sda_oe_o   = oe_q;
  assign ptr_o      = ptr_q;
  assign wr_valid_o = wv_q;
  assign wr_addr_o  = waddr_q;
  assign wr_data_o  = wdata_q;
  assign commit_o   = commit_q;
  assign busy_o     = busy;
endmodule

// File: rtl/i2c_fe_chk.sv
module i2c_fe_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_oe_o,
  input logic              busy_o,
  input logic              commit_o,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [ADDR_W-1:0] ptr_o
);
  // R8
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  // R7
  busy_after_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> busy_o);

  // R7
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R5
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R6
  page_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (ptr_o[PAGE_W-1:0] == wr_addr_o[PAGE_W-1:0] + PAGE_W'(1))
                && (ptr_o[ADDR_W-1:PAGE_W] == wr_addr_o[ADDR_W-1:PAGE_W]));

  // R10
  oe_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s));

  // R10
  oe_fall_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !$past(scl_s));
endmodule

bind i2c_eeprom_slave_fe i2c_fe_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .commit_o   (commit_o),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .ptr_o      (ptr_o)
);

// File: tb/tb_i2c_eeprom_slave_fe.sv
module tb_i2c_eeprom_slave_fe;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int WRC        = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line;
  logic sda_oe_o, wr_valid_o, commit_o, busy_o;
  logic [10:0] ptr_o, wr_addr_o;
  logic [7:0]  wr_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe_o;

  i2c_eeprom_slave_fe #(.WR_CYCLES(WRC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .ptr_o(ptr_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .commit_o(commit_o),
    .busy_o(busy_o)
  );

  int n_checks = 0, n_err = 0;
  int wr_cnt = 0, commit_cnt = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, fed by the same pin history
  int m_state, m_cnt, m_timer;
  logic [7:0] m_sh, m_wdata;
  logic [2:0] m_blk;
  logic [10:0] m_ptr, m_waddr;
  logic m_oe, m_got, m_commit, m_wv;
  logic [2:0] hs, hd;
  logic scl_at_pos;

  always @(posedge clk) begin
    scl_at_pos = m_scl;
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_timer = 0; m_sh = 0; m_wdata = 0; m_blk = 0;
      m_ptr = 0; m_waddr = 0; m_oe = 0; m_got = 0; m_commit = 0; m_wv = 0;
      hs = 3'b111; hd = 3'b111;
    end else begin
      logic cs, ps, cd, pd, line_now, old_commit, old_busy;
      line_now   = m_sda & ~m_oe;
      cs = hs[1]; ps = hs[2]; cd = hd[1]; pd = hd[2];
      old_commit = m_commit;
      old_busy   = (m_timer != 0);
      m_commit = 0; m_wv = 0;
      if (cs && ps && pd && !cd) begin
        m_state = 1; m_cnt = 0; m_oe = 0; m_got = 0;
      end else if (cs && ps && !pd && cd) begin
        m_commit = m_got && !old_busy;
        m_state = 0; m_cnt = 0; m_oe = 0; m_got = 0;
      end else if (cs && !ps) begin
        if (m_state != 0 && m_cnt < 8) m_sh = {m_sh[6:0], cd};
        if ((m_state != 0 || m_cnt == 8) && m_cnt < 9) m_cnt++;
      end else if (!cs && ps) begin
        if (m_cnt == 9) begin
          m_oe = 0; m_cnt = 0;
        end else if (m_cnt == 8 && m_state == 1) begin
          if (m_sh[7:4] == 4'hA && !old_busy) begin
            m_oe = 1; m_blk = m_sh[3:1];
            m_state = m_sh[0] ? 0 : 2;
          end else m_state = 0;
        end else if (m_cnt == 8 && m_state == 2) begin
          m_oe = 1; m_ptr = {m_blk, m_sh}; m_state = 3;
        end else if (m_cnt == 8 && m_state == 3) begin
          m_oe = 1; m_wv = 1; m_waddr = m_ptr; m_wdata = m_sh; m_got = 1;
          m_ptr[3:0] = m_ptr[3:0] + 4'd1;
        end
      end
      if (old_commit) m_timer = WRC;
      else if (m_timer > 0) m_timer--;
      hs = {hs[1:0], m_scl};
      hd = {hd[1:0], line_now};
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk(sda_oe_o === m_oe, "R2", "sda_oe model", sda_oe_o, m_oe);
      chk(ptr_o === m_ptr, "R4", "ptr model", ptr_o, m_ptr);
      chk(wr_valid_o === m_wv, "R5", "wr_valid model", wr_valid_o, m_wv);
      chk(wr_addr_o === m_waddr, "R5", "wr_addr model", wr_addr_o, m_waddr);
      chk(wr_data_o === m_wdata, "R5", "wr_data model", wr_data_o, m_wdata);
      chk(commit_o === m_commit, "R7", "commit model", commit_o, m_commit);
      chk(busy_o === (m_timer != 0), "R7", "busy model", busy_o, m_timer != 0);
      if (sda_oe_o !== prev_oe)
        chk(!scl_at_pos, "R10", "oe change with scl high", scl_at_pos, 0);
      if (wr_valid_o) wr_cnt++;
      if (commit_o) commit_cnt++;
    end
    prev_oe = sda_oe_o;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; w(Q); m_scl = 1; w(2*Q); m_scl = 0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1; w(Q); m_scl = 1; w(Q);
    chk(sda_oe_o === exp_ack, req, "ack on ninth clock", sda_oe_o, exp_ack);
    w(Q); m_scl = 0; w(Q);
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int wr0, cm0;
    w(5);
    // R11 reset state
    chk(sda_oe_o === 0, "R11", "reset oe", sda_oe_o, 0);
    chk(busy_o === 0, "R11", "reset busy", busy_o, 0);
    chk(ptr_o === 0, "R11", "reset ptr", ptr_o, 0);
    chk(commit_o === 0 && wr_valid_o === 0, "R11", "reset strobes", commit_o, 0);
    rst_ni = 1; w(10);

    // single byte write, block 3
    bus_start();
    send_byte(8'hA6, 1, "R2");
    send_byte(8'h5C, 1, "R4");
    send_byte(8'h3C, 1, "R5");
    bus_stop(); w(4);
    chk(commit_cnt == 1, "R7", "commit after data", commit_cnt, 1);
    chk(busy_o === 1, "R7", "busy after commit", busy_o, 1);
    chk(ptr_o === 11'h35D, "R6", "ptr after byte", ptr_o, 11'h35D);
    chk(wr_cnt == 1, "R5", "one strobe", wr_cnt, 1);

    // addressed during write cycle
    bus_start();
    send_byte(8'hA0, 0, "R8");
    bus_stop(); w(4);
    chk(commit_cnt == 1, "R8", "no commit while busy", commit_cnt, 1);
    w(WRC + 10);
    chk(busy_o === 0, "R7", "busy ends", busy_o, 0);

    // page write wrapping inside page, block 7
    bus_start();
    send_byte(8'hAE, 1, "R2");
    send_byte(8'hFE, 1, "R4");
    for (int i = 0; i < 18; i++) send_byte(8'(i * 7 + 1), 1, "R5");
    bus_stop(); w(4);
    chk(ptr_o === 11'h7F0, "R6", "ptr after page wrap", ptr_o, 11'h7F0);
    chk(wr_cnt == 19, "R5", "page strobes", wr_cnt, 19);
    chk(commit_cnt == 2, "R7", "page commit", commit_cnt, 2);
    w(WRC + 10);

    // foreign device code
    wr0 = wr_cnt; cm0 = commit_cnt;
    bus_start();
    send_byte(8'h5A, 0, "R3");
    send_byte(8'h11, 0, "R3");
    send_byte(8'h22, 0, "R3");
    bus_stop(); w(4);
    chk(wr_cnt == wr0, "R3", "no strobe after mismatch", wr_cnt, wr0);
    chk(commit_cnt == cm0 && busy_o === 0, "R3", "no commit after mismatch", commit_cnt, cm0);

    // read request
    bus_start();
    send_byte(8'hA3, 1, "R9");
    send_byte(8'h44, 0, "R9");
    bus_stop(); w(4);
    chk(wr_cnt == wr0, "R9", "no strobe after read", wr_cnt, wr0);
    chk(commit_cnt == cm0, "R9", "no commit after read", commit_cnt, cm0);

    // repeated START mid-byte
    bus_start();
    send_byte(8'hA4, 1, "R2");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte(8'hA4, 1, "R1");
    send_byte(8'h20, 1, "R1");
    send_byte(8'h99, 1, "R1");
    bus_stop(); w(4);
    chk(ptr_o === 11'h221, "R1", "ptr after restart", ptr_o, 11'h221);
    chk(commit_cnt == cm0 + 1, "R1", "commit after restart", commit_cnt, cm0 + 1);
    w(WRC + 10);

    // stop after address only
    cm0 = commit_cnt;
    bus_start();
    send_byte(8'hA2, 1, "R4");
    send_byte(8'h10, 1, "R4");
    bus_stop(); w(4);
    chk(ptr_o === 11'h110, "R4", "ptr load only", ptr_o, 11'h110);
    chk(commit_cnt == cm0 && busy_o === 0, "R7", "no commit without data", commit_cnt, cm0);

    w(10);
    summary();
  end
endmodule